// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. A fast system clock is divided down into a pixel clock. A horizontal and a vertical position counter then run at the pixel rate. From those counters the block decodes horizontal and vertical sync pulses, a data-enable window and the current column and row. It also carries 6-bit-per-channel colour data from an input port to the panel outputs. Everything runs in the system clock domain: the divider issues a one-cycle advance strobe, and the pixel-clock output is a registered waveform aligned to that strobe.

All geometry, the divisor, the pixel-clock polarity and the colour-spread mode come from configuration inputs. The block copies them into shadow registers only at a frame boundary. While the block is stopped (shadow divisor zero), it copies them on every cycle. In colour-spread mode the red output leads green by one pixel and blue trails it by one pixel, which spreads the switching activity on the panel pins.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted, both sync outputs are high, data-enable is low, column, row and all colour outputs are zero, and the pixel clock is low.
- R2: With a shadow divisor N of 1 or more, the pixel position advances once every N system cycles. The pixel clock takes its active level on the same system edge at which the panel outputs change. It holds that level for ceil(N/2) cycles and the inactive level for the rest of the period. With N = 1 it stays at the active level.
- R3: The active pixel-clock level is 1 when the polarity input is 0 (outputs change on its rising edge) and 0 when the polarity input is 1 (outputs change on its falling edge).
- R4: With a shadow divisor of zero, the pixel clock sits at the inactive level, both syncs are high, data-enable is low, and column, row and colour outputs are zero.
- R5: The column counts 0 to htotal-1 and then wraps, advancing the row. The row counts 0 to vtotal-1 and then wraps. A position reaches the column and row outputs one pixel period after it is decoded.
- R6: HSYNC is low for columns in [hsync_lo, hsync_hi) and high for all other columns.
- R7: VSYNC is low for rows in [vsync_lo, vsync_hi) and high for all other rows.
- R8: Data-enable is high only when the column is in [hlead, hlead+hactive) and the row is in [vlead, vlead+vactive). Colour outputs carry zero for a pixel outside that window.
- R9: With spread mode 0, the R, G and B outputs all show the input colour sampled for the pixel that the column, row and data-enable outputs show.
- R10: With spread mode 1, G stays aligned as in R9, R shows the following pixel's colour and B shows the preceding pixel's colour. Each is zeroed by its own pixel's window.
- R11: A change on any configuration input, including the divisor, takes effect only when the last pixel of a frame advances. The exception is a stopped block, which picks up new inputs on the next system cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DW | Pixel-clock divisor, 0 stops the display |
| cfg_pclk_fall | input | 1 | 0: outputs change on rising pixel clock, 1: on falling |
| cfg_spread | input | 1 | Colour-spread mode |
| cfg_h_total | input | CW | Pixel periods per line |
| cfg_h_lead | input | CW | Pixel periods before the first visible pixel |
| cfg_h_active | input | CW | Visible pixel periods per line |
| cfg_h_sync_lo | input | CW | Column at which HSYNC goes low |
| cfg_h_sync_hi | input | CW | Column at which HSYNC returns high |
| cfg_v_total | input | CW | Lines per frame |
| cfg_v_lead | input | CW | Lines before the first visible line |
| cfg_v_active | input | CW | Visible lines per frame |
| cfg_v_sync_lo | input | CW | Row at which VSYNC goes low |
| cfg_v_sync_hi | input | CW | Row at which VSYNC returns high |
| pix_r | input | CH | Red data for the pixel being decoded |
| pix_g | input | CH | Green data for the pixel being decoded |
| pix_b | input | CH | Blue data for the pixel being decoded |
| lcd_pclk | output | 1 | Pixel clock |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data-enable |
| lcd_col | output | CW | Column of the pixel on the outputs |
| lcd_row | output | CW | Row of the pixel on the outputs |
| lcd_r | output | CH | Red output |
| lcd_g | output | CH | Green output |
| lcd_b | output | CH | Blue output |

## Verification
The shadow registers latch one system edge after a stopped block sees its inputs. The first advance strobe comes N edges after that, and colour sampled at an advance reaches the pins at the next advance; in spread mode red arrives one advance sooner and blue one advance later. The bench drives inputs at the falling edge and steps a cycle-level reference model once per rising edge. It then compares every output at the following falling edge, so each expected value already counts every register on its path. Mid-frame configuration writes check that nothing moves before the frame wraps.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

   typedef enum logic {
      PCLK_RISE_ACTIVE = 1'b0,
      PCLK_FALL_ACTIVE = 1'b1
   } pclk_edge_e;

   typedef enum logic {
      SPREAD_OFF = 1'b0,
      SPREAD_ON  = 1'b1
   } spread_e;

   // high outside [lo, hi), low inside
   function automatic logic sync_level(input int unsigned pos,
                                       input int unsigned lo,
                                       input int unsigned hi);
      return (pos < lo) || (pos >= hi);
   endfunction

   // true inside [lead, lead+span)
   function automatic logic in_window(input int unsigned pos,
                                      input int unsigned lead,
                                      input int unsigned span);
      return (pos >= lead) && (pos < lead + span);
   endfunction

endpackage

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [DW-1:0] div,
   input  logic          fall,
   output logic          tick,
   output logic          pclk
);
   localparam int HW = DW + 1;

   logic [DW-1:0] cnt_q, cnt_nx;
   logic [HW-1:0] half;

   always_comb begin
      tick   = run && (cnt_q == div - 1'b1);
      cnt_nx = tick ? '0 : cnt_q + 1'b1;
      half   = ({1'b0, div} + 1'b1) >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pclk  <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         pclk  <= fall;
      end else begin
         cnt_q <= cnt_nx;
         pclk  <= ({1'b0, cnt_nx} < half) ? ~fall : fall;
      end
   end
endmodule

// File: rtl/lcd_tg_raster.sv
module lcd_tg_raster #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [CW-1:0] h_total,
   input  logic [CW-1:0] v_total,
   output logic [CW-1:0] hcnt,
   output logic [CW-1:0] vcnt,
   output logic          frame_end
);
   logic h_last, v_last;

   always_comb begin
      h_last    = (hcnt == h_total - 1'b1);
      v_last    = (vcnt == v_total - 1'b1);
      frame_end = tick && h_last && v_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (!run) begin
         hcnt <= '0;
         vcnt <= '0;
      end else if (tick) begin
         if (h_last) begin
            hcnt <= '0;
            vcnt <= v_last ? '0 : vcnt + 1'b1;
         end else begin
            hcnt <= hcnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/lcd_tg_pixpipe.sv
module lcd_tg_pixpipe #(
   parameter int CW        = 12,
   parameter int CH        = 6,
   parameter bit SPREAD_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic          spread,
   input  logic          hs_in,
   input  logic          vs_in,
   input  logic          de_in,
   input  logic [CW-1:0] col_in,
   input  logic [CW-1:0] row_in,
   input  logic [CH-1:0] r_in,
   input  logic [CH-1:0] g_in,
   input  logic [CH-1:0] b_in,
   output logic          hs_o,
   output logic          vs_o,
   output logic          de_o,
   output logic [CW-1:0] col_o,
   output logic [CW-1:0] row_o,
   output logic [CH-1:0] r_o,
   output logic [CH-1:0] g_o,
   output logic [CH-1:0] b_o
);
   logic          s1_hs, s1_vs, s1_de;
   logic [CW-1:0] s1_col, s1_row;
   logic [CH-1:0] s1_r, s1_g, s1_b;
   logic [CH-1:0] r_gate, g_gate, b_gate;
   logic [CH-1:0] r_nx, b_nx;

   always_comb begin
      r_gate = de_in ? r_in : '0;
      g_gate = de_in ? g_in : '0;
      b_gate = de_in ? b_in : '0;
   end

   generate
      if (SPREAD_EN) begin : g_spread
         logic [CH-1:0] b_s2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      b_s2 <= '0;
            else if (!run)   b_s2 <= '0;
            else if (tick)   b_s2 <= s1_b;
         end
         assign r_nx = spread ? r_gate : s1_r;
         assign b_nx = spread ? b_s2   : s1_b;
      end else begin : g_plain
         assign r_nx = s1_r;
         assign b_nx = s1_b;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_hs <= 1'b1; s1_vs <= 1'b1; s1_de <= 1'b0;
         s1_col <= '0;  s1_row <= '0;
         s1_r <= '0; s1_g <= '0; s1_b <= '0;
         hs_o <= 1'b1;  vs_o <= 1'b1;  de_o <= 1'b0;
         col_o <= '0;   row_o <= '0;
         r_o <= '0; g_o <= '0; b_o <= '0;
      end else if (!run) begin
         s1_hs <= 1'b1; s1_vs <= 1'b1; s1_de <= 1'b0;
         s1_col <= '0;  s1_row <= '0;
         s1_r <= '0; s1_g <= '0; s1_b <= '0;
         hs_o <= 1'b1;  vs_o <= 1'b1;  de_o <= 1'b0;
         col_o <= '0;   row_o <= '0;
         r_o <= '0; g_o <= '0; b_o <= '0;
      end else if (tick) begin
         s1_hs  <= hs_in;  s1_vs  <= vs_in;  s1_de <= de_in;
         s1_col <= col_in; s1_row <= row_in;
         s1_r   <= r_gate; s1_g   <= g_gate; s1_b  <= b_gate;
         hs_o   <= s1_hs;  vs_o   <= s1_vs;  de_o  <= s1_de;
         col_o  <= s1_col; row_o  <= s1_row;
         g_o    <= s1_g;
         r_o    <= r_nx;
         b_o    <= b_nx;
      end
   end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int CW        = 12,
   parameter int DW        = 8,
   parameter int CH        = 6,
   parameter bit SPREAD_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] cfg_div,
   input  logic          cfg_pclk_fall,
   input  logic          cfg_spread,
   input  logic [CW-1:0] cfg_h_total,
   input  logic [CW-1:0] cfg_h_lead,
   input  logic [CW-1:0] cfg_h_active,
   input  logic [CW-1:0] cfg_h_sync_lo,
   input  logic [CW-1:0] cfg_h_sync_hi,
   input  logic [CW-1:0] cfg_v_total,
   input  logic [CW-1:0] cfg_v_lead,
   input  logic [CW-1:0] cfg_v_active,
   input  logic [CW-1:0] cfg_v_sync_lo,
   input  logic [CW-1:0] cfg_v_sync_hi,
   input  logic [CH-1:0] pix_r,
   input  logic [CH-1:0] pix_g,
   input  logic [CH-1:0] pix_b,
   output logic          lcd_pclk,
   output logic          lcd_hsync,
   output logic          lcd_vsync,
   output logic          lcd_de,
   output logic [CW-1:0] lcd_col,
   output logic [CW-1:0] lcd_row,
   output logic [CH-1:0] lcd_r,
   output logic [CH-1:0] lcd_g,
   output logic [CH-1:0] lcd_b
);
   localparam int AXW = 5 * CW;

   typedef struct packed {
      logic [CW-1:0] total;
      logic [CW-1:0] lead;
      logic [CW-1:0] active;
      logic [CW-1:0] sync_lo;
      logic [CW-1:0] sync_hi;
   } axis_cfg_t;

   generate
      if (CW < 2 || CW > 16) begin : g_bad_cw
         $error("lcd_timing_gen: CW must lie in 2..16");
      end
      if (DW < 1 || DW > 16) begin : g_bad_dw
         $error("lcd_timing_gen: DW must lie in 1..16");
      end
      if (CH < 1) begin : g_bad_ch
         $error("lcd_timing_gen: CH must be at least 1");
      end
      if ($bits(axis_cfg_t) != AXW) begin : g_bad_axis
         $error("lcd_timing_gen: axis record width mismatch");
      end
   endgenerate

   axis_cfg_t     sh_h, sh_v;
   logic [DW-1:0] sh_div;
   pclk_edge_e    sh_pol;
   spread_e       sh_spread;
   logic          sh_run, load;
   logic          tick, frame_end;
   logic [CW-1:0] hcnt, vcnt;
   logic          hs_d, vs_d, de_d;

   assign sh_run = (sh_div != '0);
   assign load   = !sh_run || frame_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_h      <= '0;
         sh_v      <= '0;
         sh_div    <= '0;
         sh_pol    <= PCLK_RISE_ACTIVE;
         sh_spread <= SPREAD_OFF;
      end else if (load) begin
         sh_h      <= '{cfg_h_total, cfg_h_lead, cfg_h_active, cfg_h_sync_lo, cfg_h_sync_hi};
         sh_v      <= '{cfg_v_total, cfg_v_lead, cfg_v_active, cfg_v_sync_lo, cfg_v_sync_hi};
         sh_div    <= cfg_div;
         sh_pol    <= pclk_edge_e'(cfg_pclk_fall);
         sh_spread <= spread_e'(cfg_spread);
      end
   end

   lcd_tg_clkdiv #(.DW(DW)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (sh_run),
      .div  (sh_div),
      .fall (sh_pol == PCLK_FALL_ACTIVE),
      .tick (tick),
      .pclk (lcd_pclk)
   );

   lcd_tg_raster #(.CW(CW)) u_raster (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (sh_run),
      .tick     (tick),
      .h_total  (sh_h.total),
      .v_total  (sh_v.total),
      .hcnt     (hcnt),
      .vcnt     (vcnt),
      .frame_end(frame_end)
   );

   always_comb begin
      hs_d = sync_level(32'(hcnt), 32'(sh_h.sync_lo), 32'(sh_h.sync_hi));
      vs_d = sync_level(32'(vcnt), 32'(sh_v.sync_lo), 32'(sh_v.sync_hi));
      de_d = in_window(32'(hcnt), 32'(sh_h.lead), 32'(sh_h.active)) &&
             in_window(32'(vcnt), 32'(sh_v.lead), 32'(sh_v.active));
   end

   lcd_tg_pixpipe #(.CW(CW), .CH(CH), .SPREAD_EN(SPREAD_EN)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (sh_run),
      .tick  (tick),
      .spread(sh_spread == SPREAD_ON),
      .hs_in (hs_d),
      .vs_in (vs_d),
      .de_in (de_d),
      .col_in(hcnt),
      .row_in(vcnt),
      .r_in  (pix_r),
      .g_in  (pix_g),
      .b_in  (pix_b),
      .hs_o  (lcd_hsync),
      .vs_o  (lcd_vsync),
      .de_o  (lcd_de),
      .col_o (lcd_col),
      .row_o (lcd_row),
      .r_o   (lcd_r),
      .g_o   (lcd_g),
      .b_o   (lcd_b)
   );
endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker #(
   parameter int CW = 12,
   parameter int CH = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          tick,
   input logic          pol,
   input logic          pclk,
   input logic          hs,
   input logic          vs,
   input logic          de,
   input logic [CW-1:0] col,
   input logic [CW-1:0] row,
   input logic [CH-1:0] g
);
   // R2: between advance strobes the panel outputs hold still
   p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable({hs, vs, de, col, row}));

   // R3: every advance leaves the pixel clock at its active level
   p_pclk_active_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (pclk == !$past(pol)));

   // R4: a stopped block presents an idle, blank panel
   p_stopped_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!de && hs && vs && col == '0 && row == '0 && pclk == $past(pol)));

   // R8: green, aligned with data-enable, is dark outside the window
   p_dark_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> (g == '0));
endmodule

bind lcd_timing_gen lcd_tg_checker #(.CW(CW), .CH(CH)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .run  (sh_run),
   .tick (tick),
   .pol  (sh_pol == lcd_tg_pkg::PCLK_FALL_ACTIVE),
   .pclk (lcd_pclk),
   .hs   (lcd_hsync),
   .vs   (lcd_vsync),
   .de   (lcd_de),
   .col  (lcd_col),
   .row  (lcd_row),
   .g    (lcd_g)
);

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CW = 12;
   localparam int DW = 8;
   localparam int CH = 6;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n;
   logic [DW-1:0] cfg_div;
   logic          cfg_pclk_fall, cfg_spread;
   logic [CW-1:0] cfg_h_total, cfg_h_lead, cfg_h_active, cfg_h_sync_lo, cfg_h_sync_hi;
   logic [CW-1:0] cfg_v_total, cfg_v_lead, cfg_v_active, cfg_v_sync_lo, cfg_v_sync_hi;
   logic [CH-1:0] pix_r, pix_g, pix_b;
   logic          lcd_pclk, lcd_hsync, lcd_vsync, lcd_de;
   logic [CW-1:0] lcd_col, lcd_row;
   logic [CH-1:0] lcd_r, lcd_g, lcd_b;

   lcd_timing_gen #(.CW(CW), .DW(DW), .CH(CH)) dut (.*);

   int    n_vec = 0, n_bad = 0;
   bit    done = 1'b0;
   string phase = "";

   // reference model state
   int m_sdiv, m_spol, m_ssp;
   int m_hc, m_ho, m_ha, m_h0, m_h1, m_vc, m_vo, m_va, m_v0, m_v1;
   int m_cnt, m_h, m_v, m_pclk;
   int s_hs, s_vs, s_de, s_col, s_row, s_r, s_g, s_b;
   int o_hs, o_vs, o_de, o_col, o_row, o_r, o_g, o_b, m_b2;

   function automatic int sync_exp(int p, int lo, int hi);
      return (p < lo || p >= hi) ? 1 : 0;
   endfunction

   function automatic int win_exp(int p, int lead, int span);
      return (p >= lead && p < lead + span) ? 1 : 0;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic stages_idle();
      s_hs = 1; s_vs = 1; s_de = 0; s_col = 0; s_row = 0; s_r = 0; s_g = 0; s_b = 0;
      o_hs = 1; o_vs = 1; o_de = 0; o_col = 0; o_row = 0; o_r = 0; o_g = 0; o_b = 0;
      m_b2 = 0;
   endtask

   task automatic model_reset();
      m_sdiv = 0; m_spol = 0; m_ssp = 0;
      m_hc = 0; m_ho = 0; m_ha = 0; m_h0 = 0; m_h1 = 0;
      m_vc = 0; m_vo = 0; m_va = 0; m_v0 = 0; m_v1 = 0;
      m_cnt = 0; m_h = 0; m_v = 0; m_pclk = 0;
      stages_idle();
   endtask

   // drive fresh colour, then step the model across the coming rising edge
   task automatic advance();
      int run, tick, fend, cnt_n, dh, dv, dd, rg, gg, bg;
      pix_r = CH'($urandom);
      pix_g = CH'($urandom);
      pix_b = CH'($urandom);
      run  = (m_sdiv != 0) ? 1 : 0;
      tick = (run == 1 && m_cnt == m_sdiv - 1) ? 1 : 0;
      fend = (tick == 1 && m_h == m_hc - 1 && m_v == m_vc - 1) ? 1 : 0;
      dh = sync_exp(m_h, m_h0, m_h1);
      dv = sync_exp(m_v, m_v0, m_v1);
      dd = win_exp(m_h, m_ho, m_ha) & win_exp(m_v, m_vo, m_va);
      if (run == 0) begin
         m_cnt = 0; m_pclk = m_spol; m_h = 0; m_v = 0;
         stages_idle();
      end else begin
         cnt_n  = tick ? 0 : m_cnt + 1;
         m_pclk = (cnt_n < (m_sdiv + 1) / 2) ? 1 - m_spol : m_spol;
         m_cnt  = cnt_n;
         if (tick == 1) begin
            rg = dd ? int'(pix_r) : 0;
            gg = dd ? int'(pix_g) : 0;
            bg = dd ? int'(pix_b) : 0;
            o_hs = s_hs; o_vs = s_vs; o_de = s_de; o_col = s_col; o_row = s_row;
            o_g = s_g;
            o_r = m_ssp ? rg : s_r;
            o_b = m_ssp ? m_b2 : s_b;
            m_b2 = s_b;
            s_hs = dh; s_vs = dv; s_de = dd; s_col = m_h; s_row = m_v;
            s_r = rg; s_g = gg; s_b = bg;
            if (m_h == m_hc - 1) begin
               m_h = 0;
               m_v = (m_v == m_vc - 1) ? 0 : m_v + 1;
            end else begin
               m_h = m_h + 1;
            end
         end
      end
      if (run == 0 || fend == 1) begin
         m_sdiv = int'(cfg_div); m_spol = int'(cfg_pclk_fall); m_ssp = int'(cfg_spread);
         m_hc = int'(cfg_h_total); m_ho = int'(cfg_h_lead); m_ha = int'(cfg_h_active);
         m_h0 = int'(cfg_h_sync_lo); m_h1 = int'(cfg_h_sync_hi);
         m_vc = int'(cfg_v_total); m_vo = int'(cfg_v_lead); m_va = int'(cfg_v_active);
         m_v0 = int'(cfg_v_sync_lo); m_v1 = int'(cfg_v_sync_hi);
      end
   endtask

   task automatic compare_all();
      string tp, tr, tb;
      tp = (m_spol != 0) ? "R3" : "R2";
      tr = (m_ssp != 0) ? "R10" : "R9";
      tb = tr;
      if (phase != "") begin tp = phase; tr = phase; tb = phase; end
      chk(tp, "pclk", int'(lcd_pclk), m_pclk);
      chk((phase != "") ? phase : "R6", "hsync", int'(lcd_hsync), o_hs);
      chk((phase != "") ? phase : "R7", "vsync", int'(lcd_vsync), o_vs);
      chk((phase != "") ? phase : "R8", "de", int'(lcd_de), o_de);
      chk((phase != "") ? phase : "R5", "col", int'(lcd_col), o_col);
      chk((phase != "") ? phase : "R5", "row", int'(lcd_row), o_row);
      chk((phase != "") ? phase : "R9", "g", int'(lcd_g), o_g);
      chk(tr, "r", int'(lcd_r), o_r);
      chk(tb, "b", int'(lcd_b), o_b);
   endtask

   task automatic run_cycles(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         advance();
      end
   endtask

   task automatic set_cfg(int div, int pol, int sp);
      int hc, ho, ha, h0, h1, vc, vo, va, v0, v1;
      hc = 8 + int'($urandom % 12);
      ho = 1 + int'($urandom % 3);
      ha = hc - ho - 1 - int'($urandom % 2);
      h0 = int'($urandom % 3);
      h1 = h0 + 1 + int'($urandom % 3);
      vc = 5 + int'($urandom % 5);
      vo = 1 + int'($urandom % 2);
      va = vc - vo - 1;
      v0 = int'($urandom % 2);
      v1 = v0 + 1 + int'($urandom % 2);
      cfg_div = DW'(div); cfg_pclk_fall = 1'(pol); cfg_spread = 1'(sp);
      cfg_h_total = CW'(hc); cfg_h_lead = CW'(ho); cfg_h_active = CW'(ha);
      cfg_h_sync_lo = CW'(h0); cfg_h_sync_hi = CW'(h1);
      cfg_v_total = CW'(vc); cfg_v_lead = CW'(vo); cfg_v_active = CW'(va);
      cfg_v_sync_lo = CW'(v0); cfg_v_sync_hi = CW'(v1);
   endtask

   // one compared cycle, new configuration, then the model step
   task automatic reconfig(int div, int pol, int sp);
      @(negedge clk);
      compare_all();
      set_cfg(div, pol, sp);
      advance();
   endtask

   function automatic int frame_len();
      int d;
      d = (m_sdiv > int'(cfg_div)) ? m_sdiv : int'(cfg_div);
      if (d < 1) d = 1;
      return 20 * 10 * d + 40;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      set_cfg(2, 0, 0);
      pix_r = '0; pix_g = '0; pix_b = '0;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: idle values while reset is held
      chk("R1", "hsync", int'(lcd_hsync), 1);
      chk("R1", "vsync", int'(lcd_vsync), 1);
      chk("R1", "de", int'(lcd_de), 0);
      chk("R1", "pclk", int'(lcd_pclk), 0);
      chk("R1", "col", int'(lcd_col), 0);
      chk("R1", "rgb", int'({lcd_r, lcd_g, lcd_b}), 0);
      rst_n = 1'b1;
      advance();
      run_cycles(2 * frame_len());

      // directed: divisor and polarity variants, spread on and off
      reconfig(1, 0, 0); run_cycles(2 * frame_len());
      reconfig(3, 1, 0); run_cycles(2 * frame_len());
      reconfig(2, 0, 1); run_cycles(2 * frame_len());
      reconfig(4, 1, 1); run_cycles(2 * frame_len());

      // R4: stopped display, then restart
      reconfig(0, 1, 0); run_cycles(frame_len());
      phase = "R4";
      run_cycles(300);
      phase = "";
      reconfig(2, 1, 1); run_cycles(2 * frame_len());

      // R11: repeated mid-frame rewrites must wait for the frame wrap
      phase = "R11";
      reconfig(3, 0, 0); run_cycles(137);
      reconfig(1, 1, 1); run_cycles(211);
      reconfig(0, 0, 0); run_cycles(95);
      reconfig(2, 0, 1); run_cycles(3 * frame_len());
      phase = "";

      // constrained random configurations
      for (int k = 0; k < 10; k++) begin
         reconfig(int'($urandom % 5), int'($urandom % 2), int'($urandom % 2));
         run_cycles(int'($urandom % 600) + frame_len());
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule